// File: doc/BRIEF.md
# Rotate, Shift and Bit-Test Unit

This purely combinational datapath block serves the bit-manipulation opcode group of a classic 8-bit processor core. It takes one 8-bit operand and the current flag byte. A group select chooses among four kinds of work: a rotate or shift picked by a 3-bit operation code, a test of one bit, a clear of one bit, or a set of one bit. A 3-bit index names the bit for the last three groups. The block returns the new operand value and the new flag byte in the same cycle.

The surrounding core decodes the opcode, fetches the operand from a register or memory, and writes both outputs back. Flags use a fixed byte layout: sign in bit 7, zero in bit 6, half-carry in bit 4, parity in bit 2, subtract in bit 1 and carry in bit 0. Bits 5 and 3 are written as 0 whenever the block produces new flags.

Top module: `rsb_unit`

## Requirements
- R1: With group 0 (shift/rotate), code 0 rotates left so that old bit 7 lands in bit 0 and in carry, and code 1 rotates right so that old bit 0 lands in bit 7 and in carry.
- R2: With group 0, code 2 shifts left with the incoming carry (flag bit 0) entering bit 0 and old bit 7 becoming carry, and code 3 shifts right with the incoming carry entering bit 7 and old bit 0 becoming carry.
- R3: With group 0, code 4 shifts left with 0 entering bit 0 and old bit 7 becoming carry, and code 5 shifts right while keeping bit 7 and with old bit 0 becoming carry.
- R4: With group 0, code 6 shifts left with 1 forced into bit 0 and old bit 7 becoming carry.
- R5: With group 0, code 7 shifts right with 0 entering bit 7 and old bit 0 becoming carry.
- R6: After any group 0 operation the flag byte holds sign = result bit 7 (flag bit 7), zero = result is 0 (bit 6), parity = 1 for an even count of ones in the result (bit 2), carry as above (bit 0). Bits 5, 4, 3 and 1 are 0.
- R7: Group 1 (bit test) returns the operand unchanged. Its flags are computed from the operand ANDed with the one-hot mask of the indexed bit: sign from its bit 7, zero when it is 0, parity when it is even. Half-carry is 1, subtract is 0, bits 5 and 3 are 0, and carry is copied from the incoming flag byte.
- R8: Group 2 (bit clear) forces the indexed bit of the result to 0, keeps every other bit, and returns the incoming flag byte unchanged.
- R9: Group 3 (bit set) forces the indexed bit of the result to 1, keeps every other bit, and returns the incoming flag byte unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 8 | Operand value |
| flags_i | input | 8 | Incoming flag byte; bit 0 is the carry |
| grp_i | input | 2 | 0 shift/rotate, 1 bit test, 2 bit clear, 3 bit set |
| op_i | input | 3 | Shift/rotate code 0..7, used in group 0 |
| bit_i | input | 3 | Bit index, used in groups 1 to 3 |
| result_o | output | 8 | New operand value |
| flags_o | output | 8 | New flag byte |

## Verification
All eight shift codes are driven with all 256 operands, each with carry-in both clear and set. The incoming flag byte is all ones or all zeros, so a fill bit taken from the wrong place, a stale upper flag bit or a carry from the wrong end shows up against a bench model. The bit groups run every index over all-zero, all-one and alternating operands. This separates a mask that is off by one position from a correct one, and a test that reads the whole operand from one that reads only the masked bit. A short vector table covers hand-picked corners such as a result of zero, sign-only results and preserved carry.

// File: rtl/rsb_pkg.sv
`timescale 1ns/1ps
package rsb_pkg;

    localparam int unsigned DW    = 8;
    localparam int unsigned IDX_W = $clog2(DW);

    // flag byte bit positions
    localparam int unsigned FB_S = 7;
    localparam int unsigned FB_Z = 6;
    localparam int unsigned FB_H = 4;
    localparam int unsigned FB_P = 2;
    localparam int unsigned FB_N = 1;
    localparam int unsigned FB_C = 0;

    // bit 0 of the code: 0 = toward msb, 1 = toward lsb
    typedef enum logic [2:0] {
        SH_ROL_C = 3'd0,
        SH_ROR_C = 3'd1,
        SH_ROL_T = 3'd2,
        SH_ROR_T = 3'd3,
        SH_ASL   = 3'd4,
        SH_ASR   = 3'd5,
        SH_SL1   = 3'd6,
        SH_LSR   = 3'd7
    } shop_e;

    typedef enum logic [1:0] {
        GR_SHIFT = 2'd0,
        GR_TEST  = 2'd1,
        GR_CLR   = 2'd2,
        GR_SET   = 2'd3
    } grp_e;

    typedef struct packed {
        logic s;
        logic z;
        logic h;
        logic p;
        logic n;
        logic c;
    } flags_t;

    function automatic logic [7:0] pack_flags(flags_t f);
        logic [7:0] b;
        b       = '0;
        b[FB_S] = f.s;
        b[FB_Z] = f.z;
        b[FB_H] = f.h;
        b[FB_P] = f.p;
        b[FB_N] = f.n;
        b[FB_C] = f.c;
        return b;
    endfunction

endpackage

// File: rtl/rsb_shift_core.sv
`timescale 1ns/1ps
module rsb_shift_core
    import rsb_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input  logic [W-1:0] a_i,
    input  logic         cin_i,
    input  shop_e        op_i,
    output logic [W-1:0] r_o,
    output logic         cout_o
);
    logic toward_lsb;
    logic fill;

    assign toward_lsb = op_i[0];

    // bit entering the vacated end
    always_comb begin
        unique case (op_i)
            SH_ROL_C: fill = a_i[W-1];
            SH_ROR_C: fill = a_i[0];
            SH_ROL_T,
            SH_ROR_T: fill = cin_i;
            SH_ASL:   fill = 1'b0;
            SH_ASR:   fill = a_i[W-1];
            SH_SL1:   fill = 1'b1;
            SH_LSR:   fill = 1'b0;
            default:  fill = 1'b0;
        endcase
    end

    always_comb begin
        if (toward_lsb) begin
            r_o    = {fill, a_i[W-1:1]};
            cout_o = a_i[0];
        end else begin
            r_o    = {a_i[W-2:0], fill};
            cout_o = a_i[W-1];
        end
    end

endmodule

// File: rtl/rsb_bit_core.sv
`timescale 1ns/1ps
module rsb_bit_core
    import rsb_pkg::*;
#(
    parameter int unsigned W  = DW,
    parameter int unsigned IW = $clog2(W)
) (
    input  logic [W-1:0]  a_i,
    input  logic [IW-1:0] idx_i,
    input  grp_e          grp_i,
    output logic [W-1:0]  r_o,
    output logic [W-1:0]  masked_o
);
    logic [W-1:0] mask;

    for (genvar k = 0; k < W; k++) begin : g_mask
        assign mask[k] = (idx_i == IW'(k));
    end

    assign masked_o = a_i & mask;

    always_comb begin
        unique case (grp_i)
            GR_CLR:  r_o = a_i & ~mask;
            GR_SET:  r_o = a_i | mask;
            default: r_o = a_i;
        endcase
    end

endmodule

// File: rtl/rsb_flag_gen.sv
`timescale 1ns/1ps
module rsb_flag_gen
    import rsb_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input  logic [W-1:0] val_i,
    input  logic         c_i,
    input  logic         h_i,
    output flags_t       f_o
);
    always_comb begin
        f_o.s = val_i[W-1];
        f_o.z = (val_i == '0);
        f_o.h = h_i;
        f_o.p = ~^val_i;
        f_o.n = 1'b0;
        f_o.c = c_i;
    end

endmodule

// File: rtl/rsb_unit.sv
`timescale 1ns/1ps
module rsb_unit
    import rsb_pkg::*;
(
    input  logic [7:0] opnd_i,
    input  logic [7:0] flags_i,
    input  logic [1:0] grp_i,
    input  logic [2:0] op_i,
    input  logic [2:0] bit_i,
    output logic [7:0] result_o,
    output logic [7:0] flags_o
);
    grp_e         grp;
    shop_e        shop;
    logic [DW-1:0] sh_res;
    logic          sh_cout;
    logic [DW-1:0] bt_res;
    logic [DW-1:0] bt_masked;
    flags_t        sh_flags;
    flags_t        bt_flags;

    assign grp  = grp_e'(grp_i);
    assign shop = shop_e'(op_i);

    rsb_shift_core #(.W(DW)) u_shift (
        .a_i    (opnd_i),
        .cin_i  (flags_i[FB_C]),
        .op_i   (shop),
        .r_o    (sh_res),
        .cout_o (sh_cout)
    );

    rsb_bit_core #(.W(DW), .IW(IDX_W)) u_bit (
        .a_i      (opnd_i),
        .idx_i    (bit_i),
        .grp_i    (grp),
        .r_o      (bt_res),
        .masked_o (bt_masked)
    );

    rsb_flag_gen #(.W(DW)) u_fl_shift (
        .val_i (sh_res),
        .c_i   (sh_cout),
        .h_i   (1'b0),
        .f_o   (sh_flags)
    );

    rsb_flag_gen #(.W(DW)) u_fl_test (
        .val_i (bt_masked),
        .c_i   (flags_i[FB_C]),
        .h_i   (1'b1),
        .f_o   (bt_flags)
    );

    always_comb begin
        unique case (grp)
            GR_SHIFT: begin
                result_o = sh_res;
                flags_o  = pack_flags(sh_flags);
            end
            GR_TEST: begin
                result_o = bt_res;
                flags_o  = pack_flags(bt_flags);
            end
            default: begin
                result_o = bt_res;
                flags_o  = flags_i;
            end
        endcase
    end

endmodule

// File: rtl/rsb_unit_chk.sv
`timescale 1ns/1ps
module rsb_unit_chk (
    input logic [7:0] opnd_i,
    input logic [7:0] flags_i,
    input logic [1:0] grp_i,
    input logic [2:0] op_i,
    input logic [2:0] bit_i,
    input logic [7:0] result_o,
    input logic [7:0] flags_o
);
    always_comb begin
        if (grp_i == 2'd0) begin
            // R1 R2 R3 R4 R5
            shift_carry_chk: assert (flags_o[0] == (op_i[0] ? opnd_i[0] : opnd_i[7]));
            // R6
            shift_zero_sign_chk: assert (flags_o[6] == (result_o == 8'h00) && flags_o[7] == result_o[7]);
            // R6
            shift_parity_chk: assert (flags_o[2] == ($countones(result_o) % 2 == 0));
            // R6
            shift_clear_bits_chk: assert ((flags_o & 8'h3A) == 8'h00);
        end
        if (grp_i == 2'd1) begin
            // R7
            test_keep_chk: assert (result_o == opnd_i && flags_o[0] == flags_i[0] && flags_o[4] && !flags_o[1]);
            // R7
            test_zero_chk: assert (flags_o[6] == !opnd_i[bit_i]);
        end
        if (grp_i[1]) begin
            // R8
            modify_flags_chk: assert (flags_o == flags_i);
            // R8
            modify_single_chk: assert ($countones(result_o ^ opnd_i) <= 1);
            // R9
            modify_value_chk: assert (result_o[bit_i] == grp_i[0]);
        end
    end

endmodule

bind rsb_unit rsb_unit_chk u_chk (.*);

// File: tb/sim_rsb_unit.sv
`timescale 1ns/1ps
module sim_rsb_unit;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] opnd_i  = '0;
    logic [7:0] flags_i = '0;
    logic [1:0] grp_i   = '0;
    logic [2:0] op_i    = '0;
    logic [2:0] bit_i   = '0;
    logic [7:0] result_o;
    logic [7:0] flags_o;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done     = 1'b0;

    always #4 clk = ~clk;

    rsb_unit u0 (
        .opnd_i   (opnd_i),
        .flags_i  (flags_i),
        .grp_i    (grp_i),
        .op_i     (op_i),
        .bit_i    (bit_i),
        .result_o (result_o),
        .flags_o  (flags_o)
    );

    typedef struct packed {
        logic [1:0] g;
        logic [2:0] op;
        logic [2:0] b;
        logic [7:0] a;
        logic [7:0] f;
        logic [7:0] r;
        logic [7:0] fo;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 3'd0, 3'd0, 8'h81, 8'h00, 8'h03, 8'h05},
        '{2'd0, 3'd1, 3'd0, 8'h01, 8'h00, 8'h80, 8'h81},
        '{2'd0, 3'd2, 3'd0, 8'h80, 8'h01, 8'h01, 8'h01},
        '{2'd0, 3'd3, 3'd0, 8'h01, 8'h00, 8'h00, 8'h45},
        '{2'd0, 3'd4, 3'd0, 8'hC0, 8'hFF, 8'h80, 8'h81},
        '{2'd0, 3'd5, 3'd0, 8'h81, 8'h00, 8'hC0, 8'h85},
        '{2'd0, 3'd6, 3'd0, 8'h80, 8'h00, 8'h01, 8'h01},
        '{2'd0, 3'd7, 3'd0, 8'h01, 8'hFF, 8'h00, 8'h45},
        '{2'd1, 3'd0, 3'd7, 8'h80, 8'h01, 8'h80, 8'h91},
        '{2'd1, 3'd0, 3'd3, 8'hF7, 8'h00, 8'hF7, 8'h54},
        '{2'd2, 3'd0, 3'd0, 8'hFF, 8'hAA, 8'hFE, 8'hAA},
        '{2'd3, 3'd0, 3'd5, 8'h00, 8'h3C, 8'h20, 8'h3C}
    };

    function automatic string tag_of(logic [1:0] g, logic [2:0] op);
        if (g == 2'd1) return "R7";
        if (g == 2'd2) return "R8";
        if (g == 2'd3) return "R9";
        case (op)
            3'd0, 3'd1: return "R1,R6";
            3'd2, 3'd3: return "R2,R6";
            3'd4, 3'd5: return "R3,R6";
            3'd6:       return "R4,R6";
            default:    return "R5,R6";
        endcase
    endfunction

    function automatic logic even_ones(logic [7:0] v);
        int cnt = 0;
        for (int i = 0; i < 8; i++) cnt += int'(v[i]);
        return (cnt % 2) == 0;
    endfunction

    // {result, flags} for a shift code
    function automatic logic [15:0] ref_shift(logic [2:0] op, logic [7:0] a, logic cin);
        logic [7:0] r;
        logic       c;
        case (op)
            3'd0: begin r = (a << 1) | {7'b0, a[7]};   c = a[7]; end
            3'd1: begin r = (a >> 1) | {a[0], 7'b0};   c = a[0]; end
            3'd2: begin r = (a << 1) | {7'b0, cin};    c = a[7]; end
            3'd3: begin r = (a >> 1) | {cin, 7'b0};    c = a[0]; end
            3'd4: begin r = a << 1;                    c = a[7]; end
            3'd5: begin r = (a >> 1) | (a & 8'h80);    c = a[0]; end
            3'd6: begin r = (a << 1) | 8'h01;          c = a[7]; end
            default: begin r = a >> 1;                 c = a[0]; end
        endcase
        return {r, r[7], r == 8'h00, 1'b0, 1'b0, 1'b0, even_ones(r), 1'b0, c};
    endfunction

    task automatic check(string req, logic [15:0] got, logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: result/flags got %h exp %h (a=%h f=%h g=%0d op=%0d b=%0d)",
                     req, got, exp, opnd_i, flags_i, grp_i, op_i, bit_i);
        end
    endtask

    task automatic drive(logic [1:0] g, logic [2:0] op, logic [2:0] b,
                         logic [7:0] a, logic [7:0] f);
        @(posedge clk);
        #1;
        grp_i = g; op_i = op; bit_i = b; opnd_i = a; flags_i = f;
        @(negedge clk);
    endtask

    initial begin
        // reset state: all inputs zero gives zero result with Z and P set
        repeat (3) @(negedge clk);
        check("R6", {result_o, flags_o}, {8'h00, 8'h44});
        rst = 1'b0;

        // table of directed vectors
        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].g, TBL[i].op, TBL[i].b, TBL[i].a, TBL[i].f);
            check(tag_of(TBL[i].g, TBL[i].op), {result_o, flags_o}, {TBL[i].r, TBL[i].fo});
        end

        // exhaustive shift sweep against the model
        for (int op = 0; op < 8; op++) begin
            for (int c = 0; c < 2; c++) begin
                for (int a = 0; a < 256; a++) begin
                    drive(2'd0, 3'(op), 3'd0, 8'(a), (c != 0) ? 8'hFF : 8'h00);
                    check(tag_of(2'd0, 3'(op)), {result_o, flags_o},
                          ref_shift(3'(op), 8'(a), c != 0));
                end
            end
        end

        // bit groups over every index
        for (int k = 0; k < 8; k++) begin
            for (int j = 0; j < 4; j++) begin
                logic [7:0] a;
                logic [7:0] f;
                logic [7:0] m;
                logic [7:0] mk;
                a  = (j == 0) ? 8'h00 : (j == 1) ? 8'hFF : (j == 2) ? 8'h5A : 8'hA5;
                f  = (j[0]) ? 8'hC3 : 8'h3C;
                mk = 8'h01 << k;
                m  = a & mk;
                // R7 test
                drive(2'd1, 3'd5, 3'(k), a, f);
                check("R7", {result_o, flags_o},
                      {a, m[7], m == 8'h00, 1'b0, 1'b1, 1'b0, even_ones(m), 1'b0, f[0]});
                // R8 clear
                drive(2'd2, 3'd2, 3'(k), a, f);
                check("R8", {result_o, flags_o}, {a & ~mk, f});
                // R9 set
                drive(2'd3, 3'd7, 3'(k), a, f);
                check("R9", {result_o, flags_o}, {a | mk, f});
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule